// File: doc/BRIEF.md
# Multibit First-Order Delta-Sigma Modulator Model

This block is a cycle-level digital model of a first-order delta-sigma loop. It has one saturating integrator, a 16-level quantizer and a feedback converter whose levels can carry static errors. Each accepted input sample updates the loop once. The block then returns the new 4-bit quantizer code together with the feedback value that the code selects. The model produces both clean and impaired code streams, which train and test a downstream linearity corrector.

All internal quantities are two's-complement integers in units of 1/16 LSB. A table of 16 signed per-code offsets is added to the ideal feedback levels, which gives a chosen static DNL/INL profile. That profile can represent errors of 0.2 LSB and finer. The table is loaded through a write port that is only open while the block is held in reset, so the profile stays fixed for the whole run. A bypass input removes every offset. One instance can therefore serve as either the ideal reference loop or the impaired loop. The intended oversampling ratio is around 256.

Top module: `dsm_model`

## Requirements
- R1: While `rst_n` is low, `code` is 8, `out_valid` is 0 and the integrator holds 0.
- R2: The quantizer takes the integrator value `a` after the update and outputs code = floor((a + 128) / 16), clamped to the range 0..15. The thresholds are ideal.
- R3: On a cycle with `in_valid` high, the integrator becomes `a + in_x - fb`, where `fb` is the feedback of the code that was presented before that edge.
- R4: The ideal feedback level of code k is 16*k - 120, in 1/16 LSB units. This puts the levels at (k - 7.5) LSB.
- R5: With `bypass` low, `fb` equals the ideal level of `code` plus table entry `code`. Each entry is a signed 6-bit count of 1/16 LSB.
- R6: With `bypass` high, `fb` equals the ideal level of `code` exactly.
- R7: The integrator saturates at +8191 and at -8192 and never wraps.
- R8: A table write (`wr_en`, `wr_addr`, `wr_data`) takes effect only on a clock edge where `rst_n` is low. Writes at any other time are ignored, and the table is not cleared by reset.
- R9: Each accepted sample yields exactly one new code one clock later, marked by `out_valid`. Without `in_valid`, the code and the integrator hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; also opens the table write port |
| in_valid | input | 1 | Sample strobe |
| in_x | input | 12 | Signed input sample, in 1/16 LSB units |
| bypass | input | 1 | Use ideal feedback levels |
| wr_en | input | 1 | Offset table write enable |
| wr_addr | input | 4 | Offset table entry (quantizer code) |
| wr_data | input | 6 | Signed offset, in 1/16 LSB units |
| out_valid | output | 1 | A new code was produced this cycle |
| code | output | 4 | Quantizer code |
| fb | output | 10 | Signed feedback value for `code` |

## Verification
The bench sweeps constant inputs across the whole quantizer span. It runs each sweep once with ideal levels and once with a non-uniform offset table loaded. Comparing the two runs shows whether the offsets are added to the right code and whether they steer the loop. Runs with full-scale positive and negative inputs drive the integrator into both saturation limits and then back out. A wrap would show up as a sudden jump of the code. Patterns with gaps in the strobe, writes attempted while running and a mid-run reset show that the state holds, that the table stays frozen and that the table survives reset.

// File: rtl/dsm_model.sv
module dsm_model #(
  parameter int IN_W  = 12,
  parameter int FRAC  = 4,
  parameter int ACC_W = 14,
  parameter int OFS_W = 6,
  localparam int FB_W = FRAC + 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_x,
  input  logic                    bypass,
  input  logic                    wr_en,
  input  logic [3:0]              wr_addr,
  input  logic signed [OFS_W-1:0] wr_data,
  output logic                    out_valid,
  output logic [3:0]              code,
  output logic signed [FB_W-1:0]  fb
);
  localparam int SW = ACC_W + 2;
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc, acc_nx;
  logic [15:0][OFS_W-1:0]  tab;
  logic signed [FB_W-1:0]  lvl, ofs;
  logic signed [SW-1:0]    sum, thr;
  logic [3:0]              code_nx;

  assign lvl = $signed((FB_W'(code) << FRAC) - FB_W'(15 << (FRAC - 1)));
  assign ofs = bypass ? '0 : FB_W'($signed(tab[code]));
  assign fb  = lvl + ofs;

  always_comb begin
    sum = SW'(acc) + SW'(in_x) - SW'(fb);
    if (sum > SW'(ACC_MAX))      acc_nx = ACC_MAX;
    else if (sum < SW'(ACC_MIN)) acc_nx = ACC_MIN;
    else                         acc_nx = sum[ACC_W-1:0];
    thr = SW'(acc_nx) + SW'(8 << FRAC);
    if (thr < 0)                   code_nx = 4'd0;
    else if (thr >= (16 << FRAC))  code_nx = 4'd15;
    else                           code_nx = thr[FRAC+3:FRAC];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      code      <= 4'd8;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        acc  <= acc_nx;
        code <= code_nx;
      end
    end
  end

  always_ff @(posedge clk)
    if (!rst_n && wr_en) tab[wr_addr] <= wr_data;

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(code));  // R9
  AST_ONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R9
  AST_IDEAL_GRID: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> (fb[FRAC-1:0] == FRAC'(1 << (FRAC - 1))));  // R6
  AST_TABLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(tab));  // R8
endmodule

// File: tb/dsm_model_tb.sv
module dsm_model_tb;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0, in_valid = 0, bypass = 1, wr_en = 0;
  logic signed [11:0] in_x = 0;
  logic [3:0] wr_addr = 0;
  logic signed [5:0] wr_data = 0;
  logic out_valid;
  logic [3:0] code;
  logic signed [9:0] fb;

  int n_vec = 0, n_bad = 0;
  int ofs_m[16];
  int macc = 0, mcode = 8;
  bit finished = 0;

  dsm_model u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
    .bypass(bypass), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_valid(out_valid), .code(code), .fb(fb));

  always #(PERIOD/2) clk = ~clk;

  // R4 ideal level plus R5 offset unless bypassed (R6)
  function automatic int lvl_m(int c, bit byp);
    return c * 16 - 120 + (byp ? 0 : ofs_m[c]);
  endfunction

  // R2 ideal thresholds
  function automatic int quant_m(int a);
    int t = a + 128;
    if (t < 0) return 0;
    if (t >= 256) return 15;
    return t / 16;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(int x, bit v, bit byp, string req);
    @(negedge clk);
    in_x = 12'(x); in_valid = v; bypass = byp;
    if (v) begin
      macc = macc + x - lvl_m(mcode, byp);
      if (macc > 8191) macc = 8191;      // R7
      if (macc < -8192) macc = -8192;
      mcode = quant_m(macc);
    end
    @(posedge clk);
    #(PERIOD/4);
    chk(req, "code", int'(code), mcode);
    chk(req, "fb", int'(fb), lvl_m(mcode, byp));
    chk(req, "out_valid", int'(out_valid), int'(v));
  endtask

  task automatic do_reset(bit load);
    @(negedge clk);
    rst_n = 0; in_valid = 0;
    for (int k = 0; k < 16; k++) begin
      if (load) begin
        ofs_m[k] = ((k * 5) % 11) - 5;
        wr_en = 1; wr_addr = 4'(k); wr_data = 6'(ofs_m[k]);
      end
      @(negedge clk);
    end
    wr_en = 0;
    macc = 0; mcode = 8;
    @(negedge clk);
    bypass = 0;
    #1;
    chk("R1", "code", int'(code), 8);
    chk("R1", "out_valid", int'(out_valid), 0);
    chk("R8", "fb", int'(fb), lvl_m(8, 0));
    rst_n = 1;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset(1);
    // ideal loop sweep: R2 R3 R4 R6
    for (int x = -128; x <= 128; x += 8)
      for (int i = 0; i < 32; i++) step(x, 1, 1, "R6");
    do_reset(0);
    // impaired loop sweep: R5
    for (int x = -128; x <= 128; x += 8)
      for (int i = 0; i < 32; i++) step(x, 1, 0, "R5");
    // strobe gaps: R9
    for (int i = 0; i < 200; i++) step((i * 37) % 200 - 100, (i % 3) != 0, 0, "R9");
    // saturation both ways: R7
    for (int i = 0; i < 12; i++) step(2047, 1, 0, "R7");
    for (int i = 0; i < 24; i++) step(-2048, 1, 0, "R7");
    for (int i = 0; i < 24; i++) step(2047, 1, 1, "R7");
    for (int i = 0; i < 40; i++) step(0, 1, 0, "R3");
    // writes while running are ignored: R8
    wr_en = 1; wr_data = 6'sd31;
    for (int i = 0; i < 64; i++) begin
      wr_addr = 4'(i);
      step(i * 3 - 96, 1, 0, "R8");
    end
    wr_en = 0;
    // mid-run reset keeps the table: R1 R8
    do_reset(0);
    for (int i = 0; i < 100; i++) step(60 - i, 1, 0, "R2");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule